// File: doc/BRIEF.md
# ADC Conversion Result and Status Registers

This block is the bus-facing register slice of a multi-channel analog-to-digital converter. Each time the converter core reports a finished conversion (a one-cycle strobe with a 12-bit sample and a 3-bit channel index), the block latches the sample and channel into a global result word. It also keeps two status flags: a completion flag, and a flag that records a burst-mode sample lost before software read it.

Software uses a small register port. Reading the result word returns the sample together with its flags and clears both flags. A control register holds the burst-mode enable. Writing it asks the core to start a conversion, and it also changes the completion flag. A per-channel enable mask decides whether a finished conversion raises the level-sensitive interrupt line.

Top module: `adc_result_regs`

## Requirements
- R1: After reset the interrupt line, the start pulse, the burst output and the read data are 0, and the result word, the control register and the enable mask all read as 0.
- R2: The result word (offset 0x4) carries the sample in bits 15:4, the channel in bits 26:24, the lost-sample flag in bit 30 and the completion flag in bit 31. Every other bit reads 0.
- R3: A completion strobe latches the sample and the binary channel index (0 means channel 0, 7 means channel 7) and sets the completion flag.
- R4: A read of the result word returns the contents it had before the read, then clears the completion flag and the lost-sample flag.
- R5: A control write (offset 0x0) while no conversion is running clears the completion flag.
- R6: A control write while a conversion is running sets the completion flag.
- R7: With burst mode on, a completion that arrives while the completion flag is still set sets the lost-sample flag. With burst mode off, the lost-sample flag stays 0.
- R8: When a result-word read and a completion fall in the same cycle, the completion wins. The flag stays set, the lost-sample flag is not set by that completion, and the read returns the older contents.
- R9: The enable mask (offset 0xC) has one bit per channel in bits 7:0 and reads back with the upper bits 0. The interrupt is high only while the completion flag is set and the mask bit of the latched channel is 1.
- R10: The interrupt falls in the cycle after a result-word read clears the completion flag.
- R11: Read data is registered. It appears one cycle after the read strobe and holds until the next read. Unmapped offsets read as 0.
- R12: Control bit 0 is the burst enable. It reads back at offset 0x0 and drives the burst output. Every control write produces a one-cycle start pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| conv_done | input | 1 | One-cycle completion strobe from the converter core |
| conv_result | input | 12 | Sample that goes with the strobe |
| conv_chan | input | 3 | Channel index that goes with the strobe |
| conv_busy | input | 1 | High while the core is converting |
| burst_en | output | 1 | Burst-mode enable to the core |
| conv_start | output | 1 | One-cycle request for a new conversion |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The bench builds the block with its default of eight channels, so the mask is a full byte. This puts channel 7 and an all-ones sample within reach, and those cases check every field edge of the result word. With the full mask width, a write of all ones also shows that the unused upper mask bits read back as zero. The bench puts a read and a completion in the same cycle, and it writes the control register both while the core is busy and while it is idle. These are the orderings in which the flags are most likely to go wrong.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;
  localparam int DATA_W   = 32;
  localparam int RES_W    = 12;
  localparam int CHAN_W   = 3;
  localparam int RES_LSB  = 4;
  localparam int CHAN_LSB = 24;
  localparam int OVR_BIT  = 30;
  localparam int DONE_BIT = 31;

  localparam int OFF_CTRL  = 'h0;
  localparam int OFF_GDR   = 'h4;
  localparam int OFF_INTEN = 'hC;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_GDR   = 2'd2,
    SEL_INTEN = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic              done;
    logic              ovr;
    logic [CHAN_W-1:0] chan;
    logic [RES_W-1:0]  res;
  } gdr_t;

  function automatic logic [DATA_W-1:0] pack_gdr(gdr_t g);
    logic [DATA_W-1:0] w;
    w = '0;
    w[RES_LSB +: RES_W]   = g.res;
    w[CHAN_LSB +: CHAN_W] = g.chan;
    w[OVR_BIT]            = g.ovr;
    w[DONE_BIT]           = g.done;
    return w;
  endfunction
endpackage

// File: rtl/adc_bus_decode.sv
module adc_bus_decode
  import adc_regs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              ctrl_wr,
  output logic              inten_wr,
  output logic              gdr_rd,
  output rd_sel_e           rd_sel
);
  logic hit_ctrl, hit_gdr, hit_inten;

  always_comb begin
    hit_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
    hit_gdr   = (bus_addr == ADDR_W'(OFF_GDR));
    hit_inten = (bus_addr == ADDR_W'(OFF_INTEN));
    ctrl_wr   = bus_wr & hit_ctrl;
    inten_wr  = bus_wr & hit_inten;
    gdr_rd    = bus_rd & hit_gdr;
    if (hit_ctrl)       rd_sel = SEL_CTRL;
    else if (hit_gdr)   rd_sel = SEL_GDR;
    else if (hit_inten) rd_sel = SEL_INTEN;
    else                rd_sel = SEL_NONE;
  end
endmodule

// File: rtl/adc_capture.sv
module adc_capture
  import adc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  input  logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_busy,
  input  logic              burst_en,
  input  logic              ctrl_wr,
  input  logic              gdr_rd,
  output gdr_t              gdr_q
);
  gdr_t gdr_d;
  logic lost_sample;
  logic busy_restart;

  always_comb begin
    gdr_d        = gdr_q;
    busy_restart = ctrl_wr & conv_busy;
    lost_sample  = conv_done & burst_en & gdr_q.done & ~gdr_rd;
    if (conv_done) begin
      gdr_d.res  = conv_result;
      gdr_d.chan = conv_chan;
    end
    if (conv_done || busy_restart) gdr_d.done = 1'b1;
    else if (gdr_rd || ctrl_wr)    gdr_d.done = 1'b0;
    if (lost_sample)  gdr_d.ovr = 1'b1;
    else if (gdr_rd)  gdr_d.ovr = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gdr_q <= '0;
    else        gdr_q <= gdr_d;
  end

  a_r3_done_after_conv: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> gdr_q.done);
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (gdr_rd && !conv_done && !(ctrl_wr && conv_busy)) |=> (!gdr_q.done && !gdr_q.ovr));
  a_r6_busy_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && conv_busy) |=> gdr_q.done);
  a_r7_ovr_needs_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gdr_q.ovr) |-> $past(burst_en));
  a_r8_race_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && gdr_rd) |=> (gdr_q.done && !gdr_q.ovr));
endmodule

// File: rtl/adc_irq_mask.sv
module adc_irq_mask
  import adc_regs_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inten_wr,
  input  logic [NUM_CH-1:0] inten_wdata,
  input  logic              done,
  input  logic [CHAN_W-1:0] chan,
  output logic [NUM_CH-1:0] mask_q,
  output logic              irq
);
  logic [NUM_CH-1:0] mask_d;
  logic [NUM_CH-1:0] chan_hot;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) chan_hot[i] = (chan == CHAN_W'(i));
    mask_d = inten_wr ? inten_wdata : mask_q;
    irq    = done & |(mask_q & chan_hot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  a_r9_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && mask_q != '0));
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
  import adc_regs_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  input  logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_busy,
  output logic              burst_en,
  output logic              conv_start,
  output logic              irq
);
  localparam int MASK_PAD = DATA_W - NUM_CH;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              ctrl_wr, inten_wr, gdr_rd;
  rd_sel_e           rd_sel;
  gdr_t              gdr_q;
  logic [NUM_CH-1:0] mask_q;
  logic              burst_d, burst_q;
  logic              start_d, start_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  adc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .ctrl_wr  (ctrl_wr),
    .inten_wr (inten_wr),
    .gdr_rd   (gdr_rd),
    .rd_sel   (rd_sel)
  );

  adc_capture u_cap (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .conv_done   (conv_done),
    .conv_result (conv_result),
    .conv_chan   (conv_chan),
    .conv_busy   (conv_busy),
    .burst_en    (burst_q),
    .ctrl_wr     (ctrl_wr),
    .gdr_rd      (gdr_rd),
    .gdr_q       (gdr_q)
  );

  adc_irq_mask #(.NUM_CH(NUM_CH)) u_irq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .inten_wr    (inten_wr),
    .inten_wdata (bus_wdata[NUM_CH-1:0]),
    .done        (gdr_q.done),
    .chan        (gdr_q.chan),
    .mask_q      (mask_q),
    .irq         (irq)
  );

  always_comb begin
    burst_d = ctrl_wr ? bus_wdata[0] : burst_q;
    start_d = ctrl_wr;
    rdata_d = rdata_q;
    if (bus_rd) begin
      case (rd_sel)
        SEL_CTRL:  rdata_d = {{(DATA_W-1){1'b0}}, burst_q};
        SEL_GDR:   rdata_d = pack_gdr(gdr_q);
        SEL_INTEN: rdata_d = {{MASK_PAD{1'b0}}, mask_q};
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      burst_q <= 1'b0;
      start_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      burst_q <= burst_d;
      start_q <= start_d;
      rdata_q <= rdata_d;
    end
  end

  assign burst_en     = burst_q;
  assign conv_start   = start_q;
  assign bus_rdata    = rdata_q;
  assign unused_wdata = ^bus_wdata;

  a_r10_irq_drops_after_read: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gdr_rd && !conv_done && !(ctrl_wr && conv_busy)) |=> !irq);
  a_r12_start_follows_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_wr |=> conv_start);
  a_r12_start_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctrl_wr) |=> !conv_start);
  a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bus_rd) |=> $stable(bus_rdata));
endmodule

// File: tb/adc_result_regs_test.sv
module adc_result_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        conv_done = 1'b0, conv_busy = 1'b0;
  logic [11:0] conv_result = '0;
  logic [2:0]  conv_chan = '0;
  logic        burst_en, conv_start, irq;

  int checks = 0, errors = 0;
  bit finished = 0, pend = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  adc_result_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_done(conv_done), .conv_result(conv_result), .conv_chan(conv_chan),
    .conv_busy(conv_busy), .burst_en(burst_en), .conv_start(conv_start),
    .irq(irq)
  );

  function automatic logic [31:0] gdr(logic [11:0] r, logic [2:0] c, logic o, logic d);
    return {d, o, 3'b000, c, 8'h00, r, 4'h0};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: a read seen at a rising edge is compared at the next falling edge
  always @(posedge clk) if (bus_rd) pend = 1;
  always @(negedge clk) begin
    if (pend) begin
      pend = 0;
      if (exp_q.size() == 0) check("R11 unexpected read data", 32'h1, 32'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic conv(logic [11:0] r, logic [2:0] c);
    @(negedge clk);
    conv_done = 1'b1; conv_result = r; conv_chan = c;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 burst", {31'b0, burst_en}, 32'h0);
    check("R1 start", {31'b0, conv_start}, 32'h0);
    rd(4'h4, 32'h0, "R1 result word");
    rd(4'hC, 32'h0, "R1 mask");
    rd(4'h0, 32'h0, "R1 control");

    conv(12'hABC, 3'd5);
    rd(4'h4, gdr(12'hABC, 3'd5, 0, 1), "R2 R3 layout and latch");
    rd(4'h4, gdr(12'hABC, 3'd5, 0, 0), "R4 flag cleared by read");

    wr(4'hC, 32'h20);
    rd(4'hC, 32'h20, "R9 mask readback");
    conv(12'h123, 3'd5);
    check("R9 irq on enabled channel", {31'b0, irq}, 32'h1);
    rd(4'h4, gdr(12'h123, 3'd5, 0, 1), "R4 read before clear");
    check("R10 irq dropped", {31'b0, irq}, 32'h0);
    conv(12'h456, 3'd2);
    check("R9 irq masked channel", {31'b0, irq}, 32'h0);
    rd(4'h4, gdr(12'h456, 3'd2, 0, 1), "R3 channel 2");

    conv(12'h111, 3'd1);
    conv(12'h222, 3'd3);
    rd(4'h4, gdr(12'h222, 3'd3, 0, 1), "R7 no overrun without burst");

    conv(12'h333, 3'd4);
    wr(4'h0, 32'h1);
    check("R12 start pulse", {31'b0, conv_start}, 32'h1);
    check("R12 burst output", {31'b0, burst_en}, 32'h1);
    @(negedge clk);
    check("R12 start single cycle", {31'b0, conv_start}, 32'h0);
    rd(4'h0, 32'h1, "R12 control readback");
    rd(4'h4, gdr(12'h333, 3'd4, 0, 0), "R5 idle control write clears");

    conv(12'h444, 3'd6);
    conv(12'h555, 3'd7);
    rd(4'h4, gdr(12'h555, 3'd7, 1, 1), "R7 burst overrun");
    rd(4'h4, gdr(12'h555, 3'd7, 0, 0), "R4 overrun cleared");

    conv(12'h666, 3'd0);
    exp_q.push_back(gdr(12'h666, 3'd0, 0, 1));
    tag_q.push_back("R8 read returns older contents");
    @(negedge clk);
    bus_addr = 4'h4; bus_rd = 1'b1;
    conv_done = 1'b1; conv_result = 12'h777; conv_chan = 3'd1;
    @(negedge clk);
    bus_rd = 1'b0; conv_done = 1'b0;
    rd(4'h4, gdr(12'h777, 3'd1, 0, 1), "R8 completion wins");

    @(negedge clk);
    conv_busy = 1'b1;
    wr(4'h0, 32'h1);
    conv_busy = 1'b0;
    rd(4'h4, gdr(12'h777, 3'd1, 0, 1), "R6 busy control write sets");

    rd(4'h8, 32'h0, "R11 unmapped offset");
    repeat (2) @(negedge clk);
    check("R11 rdata holds", bus_rdata, 32'h0);

    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, 32'h0000_00FF, "R9 mask width");
    conv(12'hFFF, 3'd7);
    check("R9 irq channel 7", {31'b0, irq}, 32'h1);
    rd(4'h4, 32'h8700_FFF0, "R2 all-ones field edges");

    repeat (3) @(negedge clk);
    check("R11 scoreboard drained", exp_q.size(), 32'h0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule